// File: doc/BRIEF.md
# Dual-Side Integration Sequencer

This block paces a two-channel integrating front end that runs in non-continuous mode. The two sides integrate one after the other as a pair, A then B or B then A. After the pair, neither side integrates while each side's result is measured, its integrator reset and auto-zeroed. Every interval is a count of clock cycles set by a parameter. The analog path, the conversion itself and the serial readout are not part of this block. It models only the state sequence, the per-side busy flags and the data-ready strobe.

The sequencer shows its position as a numbered state. States 3 to 6 are integrating states and states 1 and 2 are idle. State 1 waits until both sides have finished measure/reset/auto-zero. State 2 is a fixed preparation interval. At the end of state 2 the convert input chooses which side integrates first. When the first integration of a pair ends, a timer starts. It strobes the active-low data-valid output once for the first side and once more later for the second side. A side-select output names the side being flagged.

The second strobe of a pair must come before the first integration of the next pair ends. With the default values this holds because the integration interval is long. A caller that shortens the intervals must keep the same ordering.

Top module: `dual_int_seq`

## Requirements
- R1: Synchronous reset (active high) sets the state to 1, clears both busy flags, drives data-valid high and stops all integration.
- R2: The state only follows the paths 1 -> 2, 2 -> 3 -> 4 -> 1 and 2 -> 6 -> 5 -> 1. A state may also repeat.
- R3: On the last cycle of state 2, a low convert input makes the next state 3, where side A integrates first. A high convert input makes the next state 6, where side B integrates first.
- R4: Each integrating state lasts exactly INT_CYC cycles. `int_a_o` is high only in states 3 and 5, and `int_b_o` only in states 4 and 6.
- R5: A side's busy flag (`busy_o` bit 0 = A, bit 1 = B) goes high on the clock edge that ends that side's integration. It stays high for exactly MRAZ_CYC cycles.
- R6: State 1 is held while either busy flag is set. It moves to state 2 on the first edge at which both flags are clear.
- R7: State 2 lasts exactly PREP_CYC cycles.
- R8: Counting k as the edges since the edge that ended the first integration of a pair, `dvalid_n_o` is low for k in [DV_DELAY, DV_DELAY+DV_WIDTH). During that window `dsel_o` names the first side (0 = A, 1 = B).
- R9: `dvalid_n_o` is also low for k in [DV_DELAY+DV_GAP, DV_DELAY+DV_GAP+DV_WIDTH), with `dsel_o` naming the second side. It is high at every other time, and `dsel_o` is steady while `dvalid_n_o` stays low.
- R10: A side never integrates while its own busy flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_i | input | 1 | Convert level; picks the first side of the next pair |
| state_o | output | 3 | Current state number, 1 to 6 |
| int_a_o | output | 1 | Side A is integrating |
| int_b_o | output | 1 | Side B is integrating |
| busy_o | output | 2 | Measure/reset/auto-zero busy flags, bit 0 = A, bit 1 = B |
| dvalid_n_o | output | 1 | Data-ready strobe, active low |
| dsel_o | output | 1 | Side whose result is flagged, 0 = A, 1 = B |

## Verification
The bench builds the block with INT_CYC=5, MRAZ_CYC=12, PREP_CYC=3, DV_DELAY=4, DV_GAP=9 and DV_WIDTH=2. These values make a whole pair cycle take a few dozen clocks, so thousands of cycles cover many pairs on both paths. Side B's busy interval outlasts the pair, so state 1 really waits. The second data-valid strobe falls while the sequencer is idle, well before the next pair ends. A reset in the middle of a run shows that the sequence starts again cleanly from state 1.

// File: rtl/dis_pkg.sv
package dis_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_FREE = 3'd1,
        ST_PREPARE   = 3'd2,
        ST_A_LEAD    = 3'd3,
        ST_B_TRAIL   = 3'd4,
        ST_A_TRAIL   = 3'd5,
        ST_B_LEAD    = 3'd6
    } seq_state_e;

    localparam int unsigned SIDES = 2;
    localparam int unsigned SIDE_A = 0;
    localparam int unsigned SIDE_B = 1;

endpackage

// File: rtl/dis_busy_timer.sv
module dis_busy_timer #(
    parameter int unsigned MRAZ_CYC = 9108
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o
);
    localparam int unsigned CW = $clog2(MRAZ_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(MRAZ_CYC);

    typedef struct packed {
        logic [CW-1:0] left;
    } busy_s;

    busy_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start_i) begin
            r_d.left = LOAD;
        end else if (r_q.left != '0) begin
            r_d.left = r_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = (r_q.left != '0);
endmodule

// File: rtl/dis_dv_timer.sv
module dis_dv_timer #(
    parameter int unsigned DV_DELAY = 4212,
    parameter int unsigned DV_GAP   = 45480,
    parameter int unsigned DV_WIDTH = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic side_i,
    output logic dvalid_n_o,
    output logic dsel_o
);
    localparam int unsigned LAST = DV_DELAY + DV_GAP + DV_WIDTH;
    localparam int unsigned CW   = $clog2(LAST + 2);
    localparam logic [CW-1:0] W1_LO = CW'(DV_DELAY);
    localparam logic [CW-1:0] W1_HI = CW'(DV_DELAY + DV_WIDTH);
    localparam logic [CW-1:0] W2_LO = CW'(DV_DELAY + DV_GAP);
    localparam logic [CW-1:0] W2_HI = CW'(LAST);

    typedef struct packed {
        logic [CW-1:0] age;
        logic          run;
        logic          first;
        logic          dvn;
        logic          sel;
    } dv_s;

    dv_s r_d, r_q;
    logic in_w1, in_w2;

    always_comb begin
        r_d   = r_q;
        in_w1 = r_q.run && (r_q.age >= W1_LO) && (r_q.age < W1_HI);
        in_w2 = r_q.run && (r_q.age >= W2_LO) && (r_q.age < W2_HI);
        if (start_i) begin
            r_d.run   = 1'b1;
            r_d.age   = CW'(1);
            r_d.first = side_i;
            r_d.dvn   = 1'b1;
        end else if (r_q.run) begin
            r_d.dvn = !(in_w1 || in_w2);
            if (in_w1) begin
                r_d.sel = r_q.first;
            end else if (in_w2) begin
                r_d.sel = !r_q.first;
            end
            if (r_q.age == W2_HI) begin
                r_d.run = 1'b0;
                r_d.age = '0;
            end else begin
                r_d.age = r_q.age + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q     <= '0;
            r_q.dvn <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign dvalid_n_o = r_q.dvn;
    assign dsel_o     = r_q.sel;
endmodule

// File: rtl/dual_int_seq.sv
module dual_int_seq
    import dis_pkg::*;
#(
    parameter int unsigned INT_CYC  = 40000,
    parameter int unsigned MRAZ_CYC = 9108,
    parameter int unsigned PREP_CYC = 240,
    parameter int unsigned DV_DELAY = 4212,
    parameter int unsigned DV_GAP   = 45480,
    parameter int unsigned DV_WIDTH = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       conv_i,
    output logic [2:0] state_o,
    output logic       int_a_o,
    output logic       int_b_o,
    output logic [1:0] busy_o,
    output logic       dvalid_n_o,
    output logic       dsel_o
);
    localparam int unsigned PH_MAX = (INT_CYC > PREP_CYC) ? INT_CYC : PREP_CYC;
    localparam int unsigned PW     = $clog2(PH_MAX + 1);
    localparam logic [PW-1:0] INT_LAST  = PW'(INT_CYC - 1);
    localparam logic [PW-1:0] PREP_LAST = PW'(PREP_CYC - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [PW-1:0] ph;
    } seq_s;

    seq_s r_d, r_q;
    logic [SIDES-1:0] side_done;
    logic [SIDES-1:0] busy;
    logic             lead_done;
    logic             lead_side;

    always_comb begin
        r_d       = r_q;
        r_d.ph    = r_q.ph + 1'b1;
        side_done = '0;
        lead_done = 1'b0;
        lead_side = 1'b0;
        unique case (r_q.st)
            ST_WAIT_FREE: begin
                r_d.ph = '0;
                if (busy == '0) begin
                    r_d.st = ST_PREPARE;
                end
            end
            ST_PREPARE: begin
                if (r_q.ph == PREP_LAST) begin
                    r_d.st = conv_i ? ST_B_LEAD : ST_A_LEAD;
                    r_d.ph = '0;
                end
            end
            ST_A_LEAD: begin
                if (r_q.ph == INT_LAST) begin
                    r_d.st            = ST_B_TRAIL;
                    r_d.ph            = '0;
                    side_done[SIDE_A] = 1'b1;
                    lead_done         = 1'b1;
                    lead_side         = 1'b0;
                end
            end
            ST_B_LEAD: begin
                if (r_q.ph == INT_LAST) begin
                    r_d.st            = ST_A_TRAIL;
                    r_d.ph            = '0;
                    side_done[SIDE_B] = 1'b1;
                    lead_done         = 1'b1;
                    lead_side         = 1'b1;
                end
            end
            ST_B_TRAIL: begin
                if (r_q.ph == INT_LAST) begin
                    r_d.st            = ST_WAIT_FREE;
                    r_d.ph            = '0;
                    side_done[SIDE_B] = 1'b1;
                end
            end
            ST_A_TRAIL: begin
                if (r_q.ph == INT_LAST) begin
                    r_d.st            = ST_WAIT_FREE;
                    r_d.ph            = '0;
                    side_done[SIDE_A] = 1'b1;
                end
            end
            default: begin
                r_d.st = ST_WAIT_FREE;
                r_d.ph = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st <= ST_WAIT_FREE;
            r_q.ph <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        dis_busy_timer #(
            .MRAZ_CYC (MRAZ_CYC)
        ) busy_i (
            .clk     (clk),
            .rst     (rst),
            .start_i (side_done[s]),
            .busy_o  (busy[s])
        );
    end

    dis_dv_timer #(
        .DV_DELAY (DV_DELAY),
        .DV_GAP   (DV_GAP),
        .DV_WIDTH (DV_WIDTH)
    ) dv_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (lead_done),
        .side_i     (lead_side),
        .dvalid_n_o (dvalid_n_o),
        .dsel_o     (dsel_o)
    );

    assign state_o = r_q.st;
    assign int_a_o = (r_q.st == ST_A_LEAD) || (r_q.st == ST_A_TRAIL);
    assign int_b_o = (r_q.st == ST_B_LEAD) || (r_q.st == ST_B_TRAIL);
    assign busy_o  = busy;
endmodule

// File: rtl/dis_seq_chk.sv
module dis_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] state_o,
    input logic       int_a_o,
    input logic       int_b_o,
    input logic [1:0] busy_o,
    input logic       dvalid_n_o,
    input logic       dsel_o
);
    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (state_o == 3'd1 && busy_o == 2'b00 && dvalid_n_o && !int_a_o && !int_b_o));

    p_from_a_lead_r2: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd3) |=> (state_o == 3'd3 || state_o == 3'd4));

    p_from_b_lead_r2: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd6) |=> (state_o == 3'd6 || state_o == 3'd5));

    p_from_trail_r2: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd4 || state_o == 3'd5) |=> (state_o == $past(state_o) || state_o == 3'd1));

    p_from_prep_r2: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd2) |=> (state_o == 3'd2 || state_o == 3'd3 || state_o == 3'd6));

    p_busy_starts_at_end_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o[0]) |-> ($past(int_a_o) && !int_a_o));

    p_hold_while_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd1 && busy_o != 2'b00) |=> (state_o == 3'd1));

    p_sel_steady_r9: assert property (@(posedge clk) disable iff (rst)
        (!dvalid_n_o && !$past(dvalid_n_o)) |-> $stable(dsel_o));

    p_no_int_a_busy_r10: assert property (@(posedge clk) disable iff (rst)
        int_a_o |-> !busy_o[0]);

    p_no_int_b_busy_r10: assert property (@(posedge clk) disable iff (rst)
        int_b_o |-> !busy_o[1]);
endmodule

bind dual_int_seq dis_seq_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .state_o    (state_o),
    .int_a_o    (int_a_o),
    .int_b_o    (int_b_o),
    .busy_o     (busy_o),
    .dvalid_n_o (dvalid_n_o),
    .dsel_o     (dsel_o)
);

// File: tb/dual_int_seq_tb_top.sv
module dual_int_seq_tb_top;
    localparam int INT_C  = 5;
    localparam int MRAZ_C = 12;
    localparam int PREP_C = 3;
    localparam int DV_D   = 4;
    localparam int DV_G   = 9;
    localparam int DV_W   = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       conv = 1'b0;
    logic [2:0] state;
    logic       int_a, int_b, dvalid_n, dsel;
    logic [1:0] busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_int_seq #(
        .INT_CYC (INT_C), .MRAZ_CYC (MRAZ_C), .PREP_CYC (PREP_C),
        .DV_DELAY (DV_D), .DV_GAP (DV_G), .DV_WIDTH (DV_W)
    ) dut_i (
        .clk (clk), .rst (rst), .conv_i (conv), .state_o (state),
        .int_a_o (int_a), .int_b_o (int_b), .busy_o (busy),
        .dvalid_n_o (dvalid_n), .dsel_o (dsel)
    );

    // reference model variables
    int  m_st, m_ph, m_a, m_b, m_age;
    bit  m_dv_on, m_first;
    int  prev_st;
    int  n_a_lead, n_b_lead, n_pulses;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_int_a(input int s);
        return (s == 3 || s == 5) ? 1 : 0;
    endfunction

    function automatic int exp_int_b(input int s);
        return (s == 4 || s == 6) ? 1 : 0;
    endfunction

    function automatic bit in_w1(input int age);
        return age >= DV_D && age < DV_D + DV_W;
    endfunction

    function automatic bit in_w2(input int age);
        return age >= DV_D + DV_G && age < DV_D + DV_G + DV_W;
    endfunction

    function automatic bit ok_succ(input int from, input int to);
        case (from)
            1: return to == 2;
            2: return to == 3 || to == 6;
            3: return to == 4;
            6: return to == 5;
            4, 5: return to == 1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_reset();
        m_st = 1; m_ph = 0; m_a = 0; m_b = 0; m_age = 0; m_dv_on = 0; m_first = 0;
        prev_st = 1;
    endtask

    // advance the model across one rising edge with the given inputs
    task automatic model_step(input bit r, input bit cv);
        int  nst, nph;
        bit  end_a, end_b, lead;
        if (r) begin
            model_reset();
            return;
        end
        nst = m_st; nph = m_ph + 1; end_a = 0; end_b = 0; lead = 0;
        case (m_st)
            1: begin nph = 0; if (m_a == 0 && m_b == 0) nst = 2; end
            2: if (m_ph == PREP_C - 1) begin nst = cv ? 6 : 3; nph = 0; end
            3: if (m_ph == INT_C - 1) begin nst = 4; nph = 0; end_a = 1; lead = 1; end
            6: if (m_ph == INT_C - 1) begin nst = 5; nph = 0; end_b = 1; lead = 1; end
            4: if (m_ph == INT_C - 1) begin nst = 1; nph = 0; end_b = 1; end
            5: if (m_ph == INT_C - 1) begin nst = 1; nph = 0; end_a = 1; end
            default: nst = 1;
        endcase
        m_a = end_a ? MRAZ_C : (m_a > 0 ? m_a - 1 : 0);
        m_b = end_b ? MRAZ_C : (m_b > 0 ? m_b - 1 : 0);
        if (lead) begin
            m_dv_on = 1; m_age = 0; m_first = (m_st == 6);
        end else if (m_dv_on) begin
            m_age++;
            if (m_age > DV_D + DV_G + DV_W) m_dv_on = 0;
        end
        m_st = nst; m_ph = nph;
    endtask

    task automatic compare();
        string sreq;
        bit    exp_low;
        bit    exp_sel;
        case (m_st)
            1: sreq = "R6";
            2: sreq = "R7";
            3, 6: sreq = "R3";
            default: sreq = "R4";
        endcase
        check(int'(state) == m_st, sreq, int'(state), m_st);
        check(int'(int_a) == exp_int_a(m_st) && int'(int_b) == exp_int_b(m_st),
              "R4", {30'd0, int_b, int_a}, exp_int_b(m_st) * 2 + exp_int_a(m_st));
        check(busy[0] == (m_a > 0), "R5", int'(busy[0]), int'(m_a > 0));
        check(busy[1] == (m_b > 0), "R5", int'(busy[1]), int'(m_b > 0));
        check(!(int_a && busy[0]) && !(int_b && busy[1]), "R10", int'(busy), 0);
        exp_low = m_dv_on && (in_w1(m_age) || in_w2(m_age));
        exp_sel = in_w1(m_age) ? m_first : !m_first;
        if (m_dv_on && in_w2(m_age)) begin
            check(dvalid_n == !exp_low, "R9", int'(dvalid_n), int'(!exp_low));
        end else begin
            check(dvalid_n == !exp_low, "R8", int'(dvalid_n), int'(!exp_low));
        end
        if (exp_low) begin
            check(dsel == exp_sel, in_w1(m_age) ? "R8" : "R9", int'(dsel), int'(exp_sel));
            if (in_w1(m_age) && m_age == DV_D) n_pulses++;
        end
        if (int'(state) != prev_st) begin
            check(ok_succ(prev_st, int'(state)), "R2", int'(state), prev_st);
            if (state == 3'd3) n_a_lead++;
            if (state == 3'd6) n_b_lead++;
        end
        prev_st = int'(state);
    endtask

    task automatic check_reset_outputs();
        check(state == 3'd1, "R1", int'(state), 1);
        check(busy == 2'b00 && !int_a && !int_b, "R1", {29'd0, int_a, busy}, 0);
        check(dvalid_n == 1'b1, "R1", int'(dvalid_n), 1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        n_a_lead = 0; n_b_lead = 0; n_pulses = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_outputs();
        rst = 1'b0;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            // directed phases, then random convert levels
            if (cyc < 500) conv = 1'b0;
            else if (cyc < 1000) conv = 1'b1;
            else conv = 1'(($urandom() % 4) == 0);
            rst = (cyc >= 2300 && cyc < 2303);
            model_step(rst, conv);
            @(negedge clk);
            if (rst) check_reset_outputs();
            compare();
        end
        check(n_a_lead > 5, "R3", n_a_lead, 6);
        check(n_b_lead > 5, "R3", n_b_lead, 6);
        check(n_pulses > 10, "R8", n_pulses, 11);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule